// File: doc/BRIEF.md
# Ethernet PHY Status Word with Sticky Bits

This block assembles a read-only 16-bit status word for an Ethernet PHY management interface. Software polls it to see the main receive-path, PMD and auto-negotiation conditions in one read. Each status bit has its own sticky rule:

- Some bits latch high on an event pulse.
- Two bits latch low when a live level drops.
- Several bits are cleared by a read of a companion register rather than by a read of this one.

The inputs are single-cycle event pulses and live levels, plus one read strobe for this register and one for each companion register. Those companions are the receive-error counter, the false-carrier counter, the 10BASE-T status register and the auto-negotiation expansion register. The read data is combinational from the held state. A read therefore returns the held value, and any clear it causes appears from the next cycle onward. An event that arrives in the same cycle as a clearing read keeps its bit set.

Top module: `phy_sts_reg`

## Requirements
- R1: After synchronous reset the read data is 0000h, whatever the inputs.
- R2: Bits 15:14 and bits 6:0 always read 0.
- R3: Bit 13 (receive error) sets one cycle after an `rx_err_evt` pulse and stays set until a cycle with `rd_rxerr_cnt` high.
- R4: Bit 12 (polarity inverted) sets on `pol_inv_evt`. It is cleared by `rd_tbt_sts` and not by `rd_this`.
- R5: Bit 11 (false carrier) sets on `fcar_evt` and is cleared by `rd_fcar_cnt`.
- R6: Bit 10 (signal detect) is latch-low. One cycle after `sd_live` is low it reads 0, and it stays 0 until a read of this register while `sd_live` is high. From the next cycle it reads 1.
- R7: Bit 9 (descrambler lock) follows the same latch-low rule as R6, driven by `dsc_lock_live`.
- R8: Bit 8 (page received) sets on `page_rx_evt`. It is cleared by `rd_an_exp` and not by `rd_this`.
- R9: Bit 7 (interrupt pending) sets on `irq_evt` and is cleared by `rd_this`.
- R10: For the latch-high bits, an event in the same cycle as a clearing read leaves the bit set.
- R11: The value presented during a read cycle is the value held before that read. Any clear the read causes is visible only from the following cycle.
- R12: A read of this register while a latch-low live input is low leaves that bit at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_err_evt | input | 1 | Receive error event pulse |
| fcar_evt | input | 1 | False carrier event pulse |
| pol_inv_evt | input | 1 | Inverted polarity detected pulse |
| page_rx_evt | input | 1 | Auto-negotiation page received pulse |
| irq_evt | input | 1 | Interrupt request pulse |
| sd_live | input | 1 | Live 100BASE-TX signal detect level |
| dsc_lock_live | input | 1 | Live 100BASE-TX descrambler lock level |
| rd_this | input | 1 | Read strobe for this status register |
| rd_rxerr_cnt | input | 1 | Read strobe for the receive error counter |
| rd_fcar_cnt | input | 1 | Read strobe for the false carrier counter |
| rd_tbt_sts | input | 1 | Read strobe for the 10BASE-T status register |
| rd_an_exp | input | 1 | Read strobe for the auto-negotiation expansion register |
| sts_rdata | output | 16 | Status word read data |

## Verification
The assertions take each input as a clean synchronous value sampled at the clock edge. They place no restriction on read strobes overlapping one another or overlapping events, so the same-cycle cases are legal stimulus. The stimulus changes every input only on the falling clock edge, which keeps each value stable across the rising edge the design samples. The random phase sets strobe and event densities so that collisions between events and clearing reads, and drops of the live levels during reads, occur often.

// File: rtl/phy_sts_pkg.sv
package phy_sts_pkg;

    localparam int STS_W   = 16;
    localparam int N_HI    = 5;
    localparam int N_LO    = 2;
    localparam int UNDEF_W = 7;
    localparam int RSVD_W  = STS_W - UNDEF_W - N_HI - N_LO;

    // indexes into the latch-high vector
    localparam int HI_RXERR = 0;
    localparam int HI_POL   = 1;
    localparam int HI_FCAR  = 2;
    localparam int HI_PAGE  = 3;
    localparam int HI_IRQ   = 4;

    // indexes into the latch-low vector
    localparam int LO_SD  = 0;
    localparam int LO_DSC = 1;

    // field order is the software-visible bit layout (MSB first)
    typedef struct packed {
        logic [RSVD_W-1:0]  rsvd;
        logic               rx_err;
        logic               pol_inv;
        logic               fcar;
        logic               sig_det;
        logic               dsc_lock;
        logic               page_rx;
        logic               irq;
        logic [UNDEF_W-1:0] undef;
    } sts_word_t;

    function automatic sts_word_t pack_word(input logic [N_HI-1:0] hi,
                                            input logic [N_LO-1:0] lo);
        sts_word_t w;
        w          = '0;
        w.rx_err   = hi[HI_RXERR];
        w.pol_inv  = hi[HI_POL];
        w.fcar     = hi[HI_FCAR];
        w.sig_det  = lo[LO_SD];
        w.dsc_lock = lo[LO_DSC];
        w.page_rx  = hi[HI_PAGE];
        w.irq      = hi[HI_IRQ];
        return w;
    endfunction

endpackage

// File: rtl/phy_sts_latch_hi.sv
module phy_sts_latch_hi (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic q
);
    // an event in the same cycle as the clear wins
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= evt | (q & ~clr);
    end

    AST_HI_SET: assert property (@(posedge clk) disable iff (rst)
        evt |=> q);                                    // R10
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
        (q && !clr) |=> q);                            // R3
    AST_HI_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !q);                         // R11
endmodule

// File: rtl/phy_sts_latch_lo.sv
module phy_sts_latch_lo (
    input  logic clk,
    input  logic rst,
    input  logic live,
    input  logic clr,
    output logic q
);
    // reads 1 only after a read re-arms it while the live level is high
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (!live) q <= 1'b0;
        else if (clr)   q <= 1'b1;
    end

    AST_LO_DROP: assert property (@(posedge clk) disable iff (rst)
        !live |=> !q);                                 // R6
    AST_LO_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (!q && !clr) |=> !q);                          // R12
    AST_LO_REARM: assert property (@(posedge clk) disable iff (rst)
        (clr && live) |=> q);                          // R7
endmodule

// File: rtl/phy_sts_reg.sv
module phy_sts_reg
    import phy_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_err_evt,
    input  logic             fcar_evt,
    input  logic             pol_inv_evt,
    input  logic             page_rx_evt,
    input  logic             irq_evt,
    input  logic             sd_live,
    input  logic             dsc_lock_live,
    input  logic             rd_this,
    input  logic             rd_rxerr_cnt,
    input  logic             rd_fcar_cnt,
    input  logic             rd_tbt_sts,
    input  logic             rd_an_exp,
    output logic [STS_W-1:0] sts_rdata
);
    logic [N_HI-1:0] hi_evt, hi_clr, hi_q;
    logic [N_LO-1:0] lo_live, lo_q;
    sts_word_t       word;

    // each latch-high bit is cleared by the read of its owning register
    always_comb begin
        hi_evt           = '0;
        hi_clr           = '0;
        hi_evt[HI_RXERR] = rx_err_evt;
        hi_clr[HI_RXERR] = rd_rxerr_cnt;
        hi_evt[HI_POL]   = pol_inv_evt;
        hi_clr[HI_POL]   = rd_tbt_sts;
        hi_evt[HI_FCAR]  = fcar_evt;
        hi_clr[HI_FCAR]  = rd_fcar_cnt;
        hi_evt[HI_PAGE]  = page_rx_evt;
        hi_clr[HI_PAGE]  = rd_an_exp;
        hi_evt[HI_IRQ]   = irq_evt;
        hi_clr[HI_IRQ]   = rd_this;
    end

    always_comb begin
        lo_live         = '0;
        lo_live[LO_SD]  = sd_live;
        lo_live[LO_DSC] = dsc_lock_live;
    end

    for (genvar i = 0; i < N_HI; i++) begin : g_hi
        phy_sts_latch_hi u_hi (
            .clk (clk),
            .rst (rst),
            .evt (hi_evt[i]),
            .clr (hi_clr[i]),
            .q   (hi_q[i])
        );
    end

    // latch-low bits are both re-armed by a read of this register
    for (genvar j = 0; j < N_LO; j++) begin : g_lo
        phy_sts_latch_lo u_lo (
            .clk  (clk),
            .rst  (rst),
            .live (lo_live[j]),
            .clr  (rd_this),
            .q    (lo_q[j])
        );
    end

    // read data shows held state, so a clearing read returns the old value
    always_comb word = pack_word(hi_q, lo_q);
    assign sts_rdata = word;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (sts_rdata == '0));                              // R1
    AST_RXERR_SET: assert property (@(posedge clk) disable iff (rst)
        rx_err_evt |=> sts_rdata[13]);                           // R3
    AST_POL_OWN_READ: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[12] && !rd_tbt_sts) |=> sts_rdata[12]);       // R4
    AST_FCAR_CLR: assert property (@(posedge clk) disable iff (rst)
        (rd_fcar_cnt && !fcar_evt) |=> !sts_rdata[11]);          // R5
    AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[8] && !rd_an_exp) |=> sts_rdata[8]);          // R8
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (rst)
        (rd_this && !irq_evt) |=> !sts_rdata[7]);                // R9
    AST_DSC_DROP: assert property (@(posedge clk) disable iff (rst)
        !dsc_lock_live |=> !sts_rdata[9]);                       // R7
endmodule

// File: tb/test_phy_sts_reg.sv
module test_phy_sts_reg;
    logic clk = 1'b0;
    logic rst;
    logic rx_err_evt, fcar_evt, pol_inv_evt, page_rx_evt, irq_evt;
    logic sd_live, dsc_lock_live;
    logic rd_this, rd_rxerr_cnt, rd_fcar_cnt, rd_tbt_sts, rd_an_exp;
    logic [15:0] sts_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // behavioural reference state
    bit m_rxerr, m_pol, m_fcar, m_page, m_irq, m_sd, m_dsc;

    always #5 clk = ~clk;

    phy_sts_reg i_phy_sts_reg (
        .clk(clk), .rst(rst),
        .rx_err_evt(rx_err_evt), .fcar_evt(fcar_evt), .pol_inv_evt(pol_inv_evt),
        .page_rx_evt(page_rx_evt), .irq_evt(irq_evt),
        .sd_live(sd_live), .dsc_lock_live(dsc_lock_live),
        .rd_this(rd_this), .rd_rxerr_cnt(rd_rxerr_cnt), .rd_fcar_cnt(rd_fcar_cnt),
        .rd_tbt_sts(rd_tbt_sts), .rd_an_exp(rd_an_exp),
        .sts_rdata(sts_rdata)
    );

    function automatic string req_of(input int b);
        case (b)
            13: return "R3";
            12: return "R4";
            11: return "R5";
            10: return "R6";
            9:  return "R7";
            8:  return "R8";
            7:  return "R9";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [15:0] model_word();
        logic [15:0] w = 16'h0000;
        w[13] = m_rxerr; w[12] = m_pol; w[11] = m_fcar;
        w[10] = m_sd;    w[9]  = m_dsc; w[8]  = m_page; w[7] = m_irq;
        return w;
    endfunction

    task automatic check_word(input string tag);
        logic [15:0] exp = model_word();
        for (int b = 0; b < 16; b++) begin
            checks++;
            if (sts_rdata[b] !== exp[b]) begin
                errors++;
                $display("FAIL %s %s bit %0d: got %b expected %b (word %h vs %h)",
                         req_of(b), tag, b, sts_rdata[b], exp[b], sts_rdata, exp);
            end
        end
    endtask

    task automatic drive(input bit erx, input bit efc, input bit epol, input bit epg,
                         input bit eirq, input bit sd, input bit dl,
                         input bit r_me, input bit r_rx, input bit r_fc,
                         input bit r_tb, input bit r_an);
        rx_err_evt = erx; fcar_evt = efc; pol_inv_evt = epol; page_rx_evt = epg;
        irq_evt = eirq; sd_live = sd; dsc_lock_live = dl;
        rd_this = r_me; rd_rxerr_cnt = r_rx; rd_fcar_cnt = r_fc;
        rd_tbt_sts = r_tb; rd_an_exp = r_an;
    endtask

    // one cycle: inputs already driven; check the word shown during the
    // cycle (pre-clear, R11), then advance model across the rising edge
    task automatic step(input string tag);
        #2;
        check_word(tag);
        @(posedge clk);
        m_rxerr = rx_err_evt  | (m_rxerr & !rd_rxerr_cnt);
        m_pol   = pol_inv_evt | (m_pol   & !rd_tbt_sts);
        m_fcar  = fcar_evt    | (m_fcar  & !rd_fcar_cnt);
        m_page  = page_rx_evt | (m_page  & !rd_an_exp);
        m_irq   = irq_evt     | (m_irq   & !rd_this);
        if (!sd_live) m_sd = 0;  else if (rd_this) m_sd = 1;
        if (!dsc_lock_live) m_dsc = 0; else if (rd_this) m_dsc = 1;
        @(negedge clk);
    endtask

    task automatic idle(input bit sd, input bit dl);
        drive(0,0,0,0,0, sd, dl, 0,0,0,0,0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1;
        drive(1,1,1,1,1, 1,1, 0,0,0,0,0);
        repeat (3) @(negedge clk);
        rst = 0;
        m_rxerr = 0; m_pol = 0; m_fcar = 0; m_page = 0; m_irq = 0; m_sd = 0; m_dsc = 0;
        // R1: reset value with active inputs held during reset
        idle(1,1);
        step("R1 reset");

        // R6/R7 arm latch-low bits with a read while live is high
        drive(0,0,0,0,0, 1,1, 1,0,0,0,0); step("R6 arm read");
        idle(1,1); step("R6 armed");

        // R3 set then hold, cleared only by counter read
        drive(1,0,0,0,0, 1,1, 0,0,0,0,0); step("R3 pulse");
        drive(0,0,0,0,0, 1,1, 1,0,0,0,0); step("R3 own read no clear");
        drive(0,0,0,0,0, 1,1, 0,1,0,0,0); step("R3 R11 counter read");
        idle(1,1); step("R3 cleared");

        // R4/R8 not cleared by own read, cleared by owning register
        drive(0,0,1,1,0, 1,1, 0,0,0,0,0); step("R4 R8 set");
        drive(0,0,0,0,0, 1,1, 1,0,0,0,0); step("R4 R8 own read");
        idle(1,1); step("R4 R8 still set");
        drive(0,0,0,0,0, 1,1, 0,0,0,1,1); step("R4 R8 owner read");
        idle(1,1); step("R4 R8 cleared");

        // R5 and R9
        drive(0,1,0,0,1, 1,1, 0,0,0,0,0); step("R5 R9 set");
        drive(0,0,0,0,0, 1,1, 1,0,1,0,0); step("R5 R9 R11 reads");
        idle(1,1); step("R5 R9 cleared");

        // R10 event colliding with clearing read on every latch-high bit
        drive(1,1,1,1,1, 1,1, 1,1,1,1,1); step("R10 collide");
        idle(1,1); step("R10 kept");

        // R6 drop then recover: stays 0 until read
        idle(0,1); step("R6 drop");
        idle(1,1); step("R6 recovered no read");
        // R12 read while live low leaves bit 0
        drive(0,0,0,0,0, 1,0, 1,0,0,0,0); step("R12 read dsc low");
        idle(1,1); step("R12 after read");
        drive(0,0,0,0,0, 1,1, 1,0,0,0,0); step("R7 rearm");
        idle(1,1); step("R7 rearmed");

        // random phase, compared every clock
        for (int n = 0; n < 3000; n++) begin
            drive(($urandom%6)==0, ($urandom%6)==0, ($urandom%7)==0,
                  ($urandom%7)==0, ($urandom%5)==0,
                  ($urandom%5)!=0, ($urandom%4)!=0,
                  ($urandom%3)==0, ($urandom%4)==0, ($urandom%4)==0,
                  ($urandom%4)==0, ($urandom%4)==0);
            step("random");
        end

        // R1 reset mid-run with bits set
        drive(1,1,1,1,1, 1,1, 0,0,0,0,0);
        rst = 1;
        @(posedge clk); @(negedge clk);
        rst = 0;
        m_rxerr = 0; m_pol = 0; m_fcar = 0; m_page = 0; m_irq = 0; m_sd = 0; m_dsc = 0;
        idle(1,1);
        step("R1 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule